// File: doc/BRIEF.md
# Atomic Read-Modify-Write Engine

This block carries out one atomic memory operation at a time for a requester on an I/O link. It accepts a request that has already been decoded: a 40-bit byte address whose two low bits are taken as zero, a four-bit length code, the requester's unit number, a transaction tag, and one or two 64-bit operands. The length code chooses the operation. A code of 1 selects fetch-and-add. A code of 3 selects compare-and-swap. Any other code is answered with an error.

For a valid request, the engine locks the 64-bit word that holds the target address. It reads that word from a synchronous single-port memory and computes the new value. It writes the new value back when the operation calls for a write, then releases the lock. A response follows: a read-response descriptor together with the word as it was before the change. While the lock is held, another agent that presents an access to the same word receives a stall.

Top module: `atomic_rmw_engine`

## Requirements
- R1: A length code of 1 performs fetch-and-add. The word at the target is replaced by the sum of its old value and `req_operand`, modulo 2^64.
- R2: A valid request accepted at clock edge E0 follows a fixed schedule. The memory read is issued in the cycle after E0. The write, if any, is issued 3 cycles after E0 (`mem_we` high only there). `rsp_valid` is high only in the 4th cycle after E0.
- R3: A length code of 3 performs compare-and-swap. `req_operand` is written only when `req_compare` is strictly greater than the old word, both taken as unsigned. If `req_compare` is equal or smaller, no write is issued.
- R4: For a valid request, `rsp_data` is the word as read before any modification.
- R5: `req_ready` is high only while the engine is idle. A request presented while `req_ready` is low is ignored. `rsp_valid` is a single-cycle pulse.
- R6: Every response has `rsp_cmd` = 6'b110000, `rsp_bridge` = 1, `rsp_isoc` = 0, `rsp_passpw` = 0, `rsp_compat` = 0 and `rsp_count` = 1. It also carries the request's `req_unit` and `req_tag`.
- R7: Bits [2:0] of `req_addr` do not select a word. `mem_addr` equals `req_addr[39:3]` (the 64-bit word index) whenever `mem_en` is high.
- R8: A length code other than 1 or 3 causes no memory access. It produces a response in the cycle after acceptance, with `rsp_error` = 1, `rsp_nxa` = 0 and `rsp_data` = 0. `rsp_nxa` is 0 in every response.
- R9: `ext_stall` is high exactly when `ext_valid` is high, the engine is in its read, wait or write cycle, and `ext_addr[39:3]` equals the locked word index. It is low in the response cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle, request is taken this cycle |
| req_addr | input | 40 | Target byte address, low two bits implied zero |
| req_count | input | 4 | Length code: 1 fetch-and-add, 3 compare-and-swap |
| req_unit | input | 5 | Requester unit number |
| req_tag | input | 5 | Requester transaction tag |
| req_operand | input | 64 | Addend or swap value |
| req_compare | input | 64 | Compare value (compare-and-swap only) |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write when high, read when low |
| mem_addr | output | 37 | 64-bit word index |
| mem_wdata | output | 64 | Write data |
| mem_rdata | input | 64 | Read data, valid one cycle after a read strobe |
| ext_valid | input | 1 | Another agent presents an access |
| ext_addr | input | 40 | Byte address of that access |
| ext_stall | output | 1 | That access must wait |
| rsp_valid | output | 1 | Response present (one cycle) |
| rsp_cmd | output | 6 | Response command code |
| rsp_unit | output | 5 | Echoed unit number |
| rsp_tag | output | 5 | Echoed tag |
| rsp_bridge | output | 1 | Response issued by bridge |
| rsp_isoc | output | 1 | Isochronous channel flag |
| rsp_passpw | output | 1 | May-pass-posted-writes flag |
| rsp_compat | output | 1 | Compatibility-chain flag |
| rsp_error | output | 1 | Request failed |
| rsp_nxa | output | 1 | Nonexistent-target flag |
| rsp_count | output | 4 | Data length code of the response |
| rsp_data | output | 64 | Original word |

## Verification
Two functions share the same cycles and must be judged together: the lock window and the external-access check. The bench holds an external access to the word under operation, at a different dword offset, for the whole life of the request. The stall must rise in the read cycle and stay high through the write cycle. It must drop in the very cycle the response appears. A second run aims the external access at a neighbouring word, where the stall must never rise.

The request port and the response are also exercised together. A request is held valid and its fields are changed while the engine is busy. The reference model then confirms that only the first set of fields reaches memory and the response.

// File: rtl/atomic_rmw_engine.sv
module atomic_rmw_engine #(
  parameter int ADDR_W = 40,
  parameter int DATA_W = 64,
  parameter int UID_W  = 5,
  parameter int TAG_W  = 5,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CNT_W-1:0]  req_count,
  input  logic [UID_W-1:0]  req_unit,
  input  logic [TAG_W-1:0]  req_tag,
  input  logic [DATA_W-1:0] req_operand,
  input  logic [DATA_W-1:0] req_compare,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-4:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              ext_valid,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic              ext_stall,
  output logic              rsp_valid,
  output logic [5:0]        rsp_cmd,
  output logic [UID_W-1:0]  rsp_unit,
  output logic [TAG_W-1:0]  rsp_tag,
  output logic              rsp_bridge,
  output logic              rsp_isoc,
  output logic              rsp_passpw,
  output logic              rsp_compat,
  output logic              rsp_error,
  output logic              rsp_nxa,
  output logic [CNT_W-1:0]  rsp_count,
  output logic [DATA_W-1:0] rsp_data
);

  localparam int QA_W = ADDR_W - 3;
  localparam logic [CNT_W-1:0] CODE_ADD  = CNT_W'(1);
  localparam logic [CNT_W-1:0] CODE_SWAP = CNT_W'(3);

  typedef enum logic [2:0] {S_IDLE, S_READ, S_WAIT, S_WRITE, S_RESP} state_t;

  state_t            state;
  logic [QA_W-1:0]   word_q;
  logic [UID_W-1:0]  unit_q;
  logic [TAG_W-1:0]  tag_q;
  logic [DATA_W-1:0] opnd_q;
  logic [DATA_W-1:0] cmp_q;
  logic [DATA_W-1:0] orig_q;
  logic              swap_op_q;
  logic              err_q;

  logic code_ok;
  logic locked;
  logic do_write;
  logic unused_low_bits;

  assign code_ok         = (req_count == CODE_ADD) || (req_count == CODE_SWAP);
  assign locked          = (state == S_READ) || (state == S_WAIT) || (state == S_WRITE);
  assign do_write        = !swap_op_q || (cmp_q > orig_q);
  assign unused_low_bits = ^{req_addr[2:0], ext_addr[2:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      word_q    <= '0;
      unit_q    <= '0;
      tag_q     <= '0;
      opnd_q    <= '0;
      cmp_q     <= '0;
      orig_q    <= '0;
      swap_op_q <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          word_q    <= req_addr[ADDR_W-1:3];
          unit_q    <= req_unit;
          tag_q     <= req_tag;
          opnd_q    <= req_operand;
          cmp_q     <= req_compare;
          orig_q    <= '0;
          swap_op_q <= (req_count == CODE_SWAP);
          err_q     <= !code_ok;
          state     <= code_ok ? S_READ : S_RESP;
        end
        S_READ:  state <= S_WAIT;
        S_WAIT: begin
          orig_q <= mem_rdata;
          state  <= S_WRITE;
        end
        S_WRITE: state <= S_RESP;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (state == S_IDLE);

  assign mem_en    = (state == S_READ) || ((state == S_WRITE) && do_write);
  assign mem_we    = (state == S_WRITE) && do_write;
  assign mem_addr  = word_q;
  assign mem_wdata = swap_op_q ? opnd_q : (orig_q + opnd_q);

  assign ext_stall = ext_valid && locked && (ext_addr[ADDR_W-1:3] == word_q);

  assign rsp_valid  = (state == S_RESP);
  assign rsp_cmd    = 6'b110000;
  assign rsp_unit   = unit_q;
  assign rsp_tag    = tag_q;
  assign rsp_bridge = 1'b1;
  assign rsp_isoc   = 1'b0;
  assign rsp_passpw = 1'b0;
  assign rsp_compat = 1'b0;
  assign rsp_error  = err_q;
  assign rsp_nxa    = 1'b0;
  assign rsp_count  = CODE_ADD;
  assign rsp_data   = orig_q;

endmodule

// File: rtl/atomic_rmw_engine_chk.sv
module atomic_rmw_engine_chk #(
  parameter int QA_W  = 37,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             mem_en,
  input logic             mem_we,
  input logic [QA_W-1:0]  mem_addr,
  input logic             ext_stall,
  input logic             rsp_valid,
  input logic [5:0]       rsp_cmd,
  input logic             rsp_bridge,
  input logic             rsp_isoc,
  input logic             rsp_passpw,
  input logic             rsp_compat,
  input logic             rsp_nxa,
  input logic [CNT_W-1:0] rsp_count
);

  AST_RSP_FIXED_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_cmd == 6'b110000) && rsp_bridge && !rsp_isoc && !rsp_passpw
                  && !rsp_compat && (rsp_count == CNT_W'(1))); // R6

  AST_NXA_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !rsp_nxa); // R8

  AST_READ_BEFORE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we) |-> $past(mem_en && !mem_we, 2)); // R2

  AST_WRITE_SAME_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we) |-> (mem_addr == $past(mem_addr, 2))); // R7

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R5

  AST_RSP_NOT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready && !mem_en); // R5

  AST_STALL_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ext_stall |-> !req_ready && !rsp_valid); // R9

endmodule

bind atomic_rmw_engine atomic_rmw_engine_chk #(.QA_W(ADDR_W-3), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .mem_en(mem_en), .mem_we(mem_we),
  .mem_addr(mem_addr), .ext_stall(ext_stall), .rsp_valid(rsp_valid), .rsp_cmd(rsp_cmd),
  .rsp_bridge(rsp_bridge), .rsp_isoc(rsp_isoc), .rsp_passpw(rsp_passpw),
  .rsp_compat(rsp_compat), .rsp_nxa(rsp_nxa), .rsp_count(rsp_count)
);

// File: tb/atomic_rmw_engine_tb.sv
`timescale 1ns/1ps
module atomic_rmw_engine_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0;
  logic        req_ready;
  logic [39:0] req_addr = '0;
  logic [3:0]  req_count = '0;
  logic [4:0]  req_unit = '0;
  logic [4:0]  req_tag = '0;
  logic [63:0] req_operand = '0;
  logic [63:0] req_compare = '0;
  logic        mem_en, mem_we;
  logic [36:0] mem_addr;
  logic [63:0] mem_wdata;
  logic [63:0] mem_rdata = '0;
  logic        ext_valid = 0;
  logic [39:0] ext_addr = '0;
  logic        ext_stall;
  logic        rsp_valid, rsp_bridge, rsp_isoc, rsp_passpw, rsp_compat, rsp_error, rsp_nxa;
  logic [5:0]  rsp_cmd;
  logic [4:0]  rsp_unit, rsp_tag;
  logic [3:0]  rsp_count;
  logic [63:0] rsp_data;

  always #2.5 clk = ~clk;

  atomic_rmw_engine u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_count(req_count), .req_unit(req_unit), .req_tag(req_tag),
    .req_operand(req_operand), .req_compare(req_compare), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .ext_valid(ext_valid), .ext_addr(ext_addr), .ext_stall(ext_stall),
    .rsp_valid(rsp_valid), .rsp_cmd(rsp_cmd), .rsp_unit(rsp_unit), .rsp_tag(rsp_tag),
    .rsp_bridge(rsp_bridge), .rsp_isoc(rsp_isoc), .rsp_passpw(rsp_passpw),
    .rsp_compat(rsp_compat), .rsp_error(rsp_error), .rsp_nxa(rsp_nxa),
    .rsp_count(rsp_count), .rsp_data(rsp_data)
  );

  logic [63:0] bmem [16];
  logic [63:0] shadow [16];
  int n_chk = 0, n_fail = 0;
  bit run = 0, done = 0;

  int          ph = 0;
  logic [36:0] e_qa;
  logic [4:0]  e_uid, e_tag;
  logic        e_err;
  logic [63:0] e_data;
  string       e_req = "R1";

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) bmem[mem_addr[3:0]] <= mem_wdata;
      else mem_rdata <= bmem[mem_addr[3:0]];
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // reference model: ph counts cycles after acceptance; 1..3 locked, 4 = response
  always @(posedge clk) begin
    if (!rst_n) ph = 0;
    else if (ph == 0) begin
      if (req_valid) begin
        int k;
        k = int'(req_addr[6:3]);
        e_qa = req_addr[39:3]; e_uid = req_unit; e_tag = req_tag;
        if (req_count == 4'd1) begin
          e_err = 0; e_data = shadow[k]; shadow[k] = shadow[k] + req_operand; e_req = "R1"; ph = 1;
        end else if (req_count == 4'd3) begin
          e_err = 0; e_data = shadow[k];
          if (req_compare > shadow[k]) shadow[k] = req_operand;
          e_req = "R3"; ph = 1;
        end else begin
          e_err = 1; e_data = '0; e_req = "R8"; ph = 4;
        end
      end
    end else if (ph == 4) ph = 0;
    else ph = ph + 1;
  end

  always @(negedge clk) begin
    if (rst_n && run && !done) begin
      bit exp_stall;
      chk(req_ready == (ph == 0), "R5 ready", 64'(req_ready), 64'(ph == 0));
      chk(rsp_valid == (ph == 4), "R2 rsp timing", 64'(rsp_valid), 64'(ph == 4));
      exp_stall = ext_valid && ph >= 1 && ph <= 3 && ext_addr[39:3] == e_qa;
      chk(ext_stall == exp_stall, "R9 stall", 64'(ext_stall), 64'(exp_stall));
      if (mem_en) begin
        chk(ph >= 1 && ph <= 3 && !e_err, "R8 no access", 64'(ph), 64'd1);
        chk(mem_addr == e_qa, "R7 word index", 64'(mem_addr), 64'(e_qa));
        chk(mem_we == (ph == 3), "R2 write slot", 64'(mem_we), 64'(ph == 3));
        if (!mem_we) chk(ph == 1, "R2 read slot", 64'(ph), 64'd1);
      end
      if (ph == 4) begin
        chk(rsp_data == e_data, e_err ? "R8 data" : "R4 data", rsp_data, e_data);
        chk(rsp_error == e_err, "R8 error", 64'(rsp_error), 64'(e_err));
        chk(rsp_nxa == 0, "R8 nxa", 64'(rsp_nxa), 64'd0);
        chk({rsp_cmd, rsp_bridge, rsp_isoc, rsp_passpw, rsp_compat, rsp_count} == {6'b110000, 4'b1000, 4'd1},
            "R6 fixed fields", 64'({rsp_cmd, rsp_bridge, rsp_isoc, rsp_passpw, rsp_compat, rsp_count}),
            64'({6'b110000, 4'b1000, 4'd1}));
        chk(rsp_unit == e_uid && rsp_tag == e_tag, "R6 echo", 64'({rsp_unit, rsp_tag}), 64'({e_uid, e_tag}));
        for (int i = 0; i < 16; i++)
          chk(bmem[i] == shadow[i], e_req, bmem[i], shadow[i]);
      end
    end
  end

  task automatic issue(input logic [39:0] a, input logic [3:0] c, input logic [4:0] u,
                       input logic [4:0] t, input logic [63:0] op, input logic [63:0] cm,
                       input int hold);
    @(negedge clk); #1;
    while (!req_ready) begin @(negedge clk); #1; end
    req_valid = 1; req_addr = a; req_count = c; req_unit = u; req_tag = t;
    req_operand = op; req_compare = cm;
    @(negedge clk); #1;
    // fields change while busy: must be ignored (R5)
    for (int h = 0; h < hold; h++) begin
      req_tag = ~t; req_operand = ~op; req_addr = a ^ 40'h08;
      @(negedge clk); #1;
    end
    req_valid = 0;
    repeat (5) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      bmem[i] = {32'hA5A5_0000 + 32'(i), 32'h1357_9BDF * 32'(i + 1)};
      shadow[i] = bmem[i];
    end
    bmem[5] = '1; shadow[5] = '1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_en && !ext_stall, "R5 reset state",
        64'({req_ready, rsp_valid, mem_en, ext_stall}), 64'b1000);
    run = 1;

    // R1 + R9: fetch-and-add with another agent on the same word, other dword
    ext_valid = 1; ext_addr = 40'h00_8240_2024;
    issue(40'h00_8240_2020, 4'd1, 5'd2, 5'd10, 64'h104B_300B_2C3D_0042, 64'h0, 0);
    // R9: neighbouring word never stalls
    ext_addr = 40'h00_8240_2028;
    issue(40'h00_8240_2020, 4'd1, 5'd3, 5'd11, 64'h1, 64'h0, 0);
    ext_valid = 0;
    // R1: wrap-around modulo 2^64
    issue(40'h28, 4'd1, 5'd4, 5'd1, 64'h2, 64'h0, 0);
    // R3: compare greater -> swap; equal -> no; less -> no
    issue(40'h30, 4'd3, 5'd5, 5'd2, 64'hDEAD_BEEF_0000_1111, 64'hFFFF_FFFF_FFFF_FFFF, 0);
    issue(40'h38, 4'd3, 5'd6, 5'd3, 64'h1234, shadow[7], 0);
    issue(40'h40, 4'd3, 5'd7, 5'd4, 64'h5678, 64'h1, 0);
    // R8: invalid codes
    issue(40'h48, 4'd0, 5'd8, 5'd5, 64'h99, 64'h99, 0);
    issue(40'h48, 4'd2, 5'd9, 5'd6, 64'h99, 64'h99, 0);
    issue(40'h48, 4'd15, 5'd10, 5'd7, 64'h99, 64'h99, 0);
    // R7: low address bits ignored
    issue(40'h4E, 4'd1, 5'd11, 5'd8, 64'h10, 64'h0, 0);
    // R5: held request with changing fields while busy
    issue(40'h50, 4'd1, 5'd12, 5'd9, 64'h77, 64'h0, 4);
    issue(40'h58, 4'd8, 5'd13, 5'd12, 64'h77, 64'h0, 1);
    // mixed traffic with stalls probing the locked word
    for (int n = 0; n < 40; n++) begin
      logic [39:0] a;
      logic [3:0]  c;
      a = {30'h0, 4'($urandom), 3'($urandom), 3'($urandom)};
      c = (n % 5 == 4) ? 4'd2 : ((n % 2) ? 4'd3 : 4'd1);
      ext_valid = n[0]; ext_addr = (n % 3 == 0) ? a : (a ^ 40'h08);
      issue(a, c, 5'(n), 5'(n + 7), {$urandom, $urandom}, {$urandom, $urandom}, n % 3);
    end
    ext_valid = 0;
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule